// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one 32-bit integer by another over many clock cycles. It uses restoring division: each cycle it tries one subtraction and keeps the result only when it does not go negative. The partial remainder and the quotient share a single double-width register. The remainder sits in the upper half. Quotient bits enter at the bottom of the lower half as the dividend bits leave it. The arithmetic runs on operand magnitudes, so signed operation is a conversion on the way in and a sign correction on the way out.

A client pulses `start` while the block is idle. The pulse carries the operands and a mode bit that selects signed or unsigned division. `busy` stays high while the divider works. A one-cycle `done` pulse marks the cycle in which `quotient` (the low result) and `remainder` (the high result) become valid. The results then stay unchanged until the next division completes. A zero divisor does not stop the block: it sets a flag and returns fixed values.

Top module: `seq_divider`

## Requirements
- R1: When `start` is high while `busy` is low, the operands and the mode are captured at that clock edge, and `busy` reads high in the following cycle and stays high until `done` pulses.
- R2: `done` is high for exactly one cycle. Counting the start edge as edge 0, `done` rises after edge W in unsigned mode (W = 32) and after edge W+1 in signed mode, because signed mode adds one sign-correction cycle.
- R3: In unsigned mode (`is_signed` = 0) with a nonzero divisor, `quotient` is the floor of dividend / divisor, and `remainder` equals dividend − quotient × divisor, which is less than the divisor.
- R4: In signed mode (`is_signed` = 1, two's complement operands), `quotient` is the exact quotient truncated toward zero. It is negative when the operand signs differ and the magnitude is at least one.
- R5: In signed mode the remainder is zero or carries the sign of the dividend, and its magnitude is below the divisor's magnitude. So −7/2 gives −3 remainder −1, and 7/−2 gives −3 remainder +1.
- R6: A zero divisor in either mode sets `div_by_zero` high with `done`, makes `quotient` all ones and makes `remainder` equal to the raw dividend. Any nonzero divisor gives `div_by_zero` low.
- R7: A `start` pulse while `busy` is high is ignored. The operands, mode, result and latency of the division already in progress are unchanged.
- R8: `quotient`, `remainder` and `div_by_zero` keep their values after `done` until the next division completes.
- R9: Signed division of the most negative value (0x80000000) by −1 gives quotient 0x80000000 and remainder 0, the wrapped two's complement result.
- R10: After reset `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; acted on only while idle |
| is_signed | input | 1 | 1: two's complement operands; 0: unsigned |
| dividend | input | 32 | Dividend, captured with `start` |
| divisor | input | 32 | Divisor, captured with `start` |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results update |
| quotient | output | 32 | Quotient (low result) |
| remainder | output | 32 | Remainder (high result) |
| div_by_zero | output | 1 | Last completed division had a zero divisor |

## Verification
The bench covers each sign combination of ±7 and ±2. A sign rule that flooded instead of truncating, or that gave the remainder the divisor's sign, would return −4/+1 or a wrong remainder sign for −7/2. It covers 0x80000000 / −1: a design that mishandles the magnitude of the most negative value would return a wrong quotient or a nonzero remainder. It covers zero divisors in both modes: a design without the override would hand back whatever the restore path leaves in the register. It covers divisors above the dividend and all-ones operands, where a trial subtraction without its carry bit would decide quotient bits wrongly. It also fires a second `start` mid-run with different operands and the other mode: a design that did not lock out `start` would change its result or its latency.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   load_value,
  input  logic [W-1:0]   dvsr,
  output logic [2*W-1:0] rem_q,
  output logic [2*W-1:0] rem_next
);

  localparam int RW = 2 * W;

  // shift first, then try the subtraction on the upper W+1 bits
  logic [RW:0]  shifted;
  logic [W:0]   upper;
  logic [W:0]   trial;
  logic         q_bit;

  function automatic logic [W:0] try_sub(input logic [W:0] a, input logic [W-1:0] d);
    return a - {1'b0, d};
  endfunction

  always_comb begin
    shifted = {rem_q, 1'b0};
    upper   = shifted[RW:W];
    trial   = try_sub(upper, dvsr);
    q_bit   = ~trial[W];
    if (q_bit)
      rem_next = {trial[W-1:0], shifted[W-1:1], 1'b1};
    else
      rem_next = shifted[RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (load)
      rem_q <= {{W{1'b0}}, load_value};
    else if (step)
      rem_q <= rem_next;
  end

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dvsr != '0) |=> (rem_q[RW-1:W] < $past(dvsr)));

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] mag_q,
  input  logic [W-1:0] mag_r,
  input  logic         neg_q,
  input  logic         neg_r,
  output logic [W-1:0] q,
  output logic [W-1:0] r
);

  function automatic logic [W-1:0] negate_if(input logic [W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    q = negate_if(mag_q, neg_q);
    r = negate_if(mag_r, neg_r);
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);

  localparam int RW = 2 * W;
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state;
  logic          sgn_l, negq_l, negr_l, dz_l;
  logic [W-1:0]  dvd_l, dvs_l, dvs_mag;
  logic [CW-1:0] cnt;

  function automatic logic [W-1:0] mag_of(input logic [W-1:0] v, input logic s);
    return (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  // named events for the checks
  logic accept, step_en, last_step, finish;
  assign accept    = start && (state == ST_IDLE);
  assign step_en   = (state == ST_RUN);
  assign last_step = step_en && (cnt == LAST);
  assign finish    = (last_step && !sgn_l) || (state == ST_FIX);
  assign busy      = (state != ST_IDLE);

  logic [W-1:0]  dvd_mag_in;
  logic [RW-1:0] rem_q, rem_nx, src;
  logic [W-1:0]  fix_q, fix_r;

  assign dvd_mag_in = mag_of(dividend, is_signed);

  div_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .step       (step_en),
    .load_value (dvd_mag_in),
    .dvsr       (dvs_mag),
    .rem_q      (rem_q),
    .rem_next   (rem_nx)
  );

  assign src = (state == ST_FIX) ? rem_q : rem_nx;

  div_sign_fix #(.W(W)) u_fix (
    .mag_q (src[W-1:0]),
    .mag_r (src[RW-1:W]),
    .neg_q (negq_l),
    .neg_r (negr_l),
    .q     (fix_q),
    .r     (fix_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      sgn_l       <= 1'b0;
      negq_l      <= 1'b0;
      negr_l      <= 1'b0;
      dz_l        <= 1'b0;
      dvd_l       <= '0;
      dvs_l       <= '0;
      dvs_mag     <= '0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= finish;
      unique case (state)
        ST_IDLE: if (accept) begin
          sgn_l   <= is_signed;
          dvd_l   <= dividend;
          dvs_l   <= divisor;
          dvs_mag <= mag_of(divisor, is_signed);
          negq_l  <= is_signed && (dividend[W-1] ^ divisor[W-1]);
          negr_l  <= is_signed && dividend[W-1];
          dz_l    <= (divisor == '0);
          cnt     <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= sgn_l ? ST_FIX : ST_IDLE;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (finish) begin
        quotient    <= dz_l ? '1 : fix_q;
        remainder   <= dz_l ? dvd_l : fix_r;
        div_by_zero <= dz_l;
      end
    end
  end

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dvd_l) && $stable(dvs_l) && $stable(sgn_l)));

  // R3
  unsigned_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sgn_l && !dz_l) |->
      (({{W{1'b0}}, dvd_l} == ({{W{1'b0}}, quotient} * {{W{1'b0}}, dvs_l}
                               + {{W{1'b0}}, remainder})) && (remainder < dvs_l)));

  // R6
  zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_l) |-> (div_by_zero && quotient == '1 && remainder == dvd_l));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(finish)) |-> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_by_zero;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seq_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected results from plain integer arithmetic
  task automatic model(input logic s, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] q, output logic [31:0] r, output logic z);
    longint sa, sb;
    z = (b == 0);
    if (z) begin
      q = '1; r = a;
    end else if (s) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      q = 32'(sa / sb); r = 32'(sa % sb);
    end else begin
      sa = longint'({32'b0, a}); sb = longint'({32'b0, b});
      q = 32'(sa / sb); r = 32'(sa % sb);
    end
  endtask

  task automatic run_div(input logic s, input logic [31:0] a, input logic [31:0] b,
                         input bit poke, input string tag);
    logic [31:0] eq, er;
    logic ez;
    int cyc;
    string tq, tr;
    model(s, a, b, eq, er, ez);
    tq = (tag != "") ? tag : (ez ? "R6" : (s ? "R4" : "R3"));
    tr = (tag != "") ? tag : (ez ? "R6" : (s ? "R5" : "R3"));
    @(negedge clk);
    is_signed = s; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R1", 32'(busy), 32'd1);
    while (!done && cyc < 100) begin
      if (poke && cyc == 5) begin
        start = 1'b1; dividend = ~a; divisor = b + 32'd3; is_signed = ~s;
      end else if (poke && cyc == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == (s ? 34 : 33), poke ? "R7" : "R2", 32'(cyc), s ? 32'd34 : 32'd33);
    check(quotient == eq, poke ? "R7" : tq, quotient, eq);
    check(remainder == er, poke ? "R7" : tr, remainder, er);
    check(div_by_zero == ez, "R6", 32'(div_by_zero), 32'(ez));
    @(negedge clk);
    check(done == 1'b0, "R2", 32'(done), 32'd0);
    check(busy == 1'b0 && quotient == eq && remainder == er, "R8", quotient, eq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0 && div_by_zero == 0, "R10", {29'b0, busy, done, div_by_zero}, 32'd0);
    check(quotient == 0 && remainder == 0, "R10", quotient | remainder, 32'd0);
    rst_n = 1'b1;

    // R3 directed unsigned
    run_div(1'b0, 32'd7, 32'd2, 1'b0, "");
    run_div(1'b0, 32'd5, 32'd7, 1'b0, "");
    run_div(1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0, "");
    run_div(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "");
    run_div(1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "");
    run_div(1'b0, 32'd0, 32'd5, 1'b0, "");
    // R4 R5 sign combinations
    run_div(1'b1, 32'd7, 32'd2, 1'b0, "");
    run_div(1'b1, -32'sd7, 32'd2, 1'b0, "");
    run_div(1'b1, 32'd7, -32'sd2, 1'b0, "");
    run_div(1'b1, -32'sd7, -32'sd2, 1'b0, "");
    run_div(1'b1, -32'sd1, 32'd5, 1'b0, "");
    // R9
    run_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R9");
    run_div(1'b1, 32'h8000_0000, 32'd1, 1'b0, "");
    // R6 zero divisor both modes
    run_div(1'b0, 32'd12345, 32'd0, 1'b0, "");
    run_div(1'b1, -32'sd99, 32'd0, 1'b0, "");
    // R7 start during busy, both modes
    run_div(1'b0, 32'd1000, 32'd7, 1'b1, "");
    run_div(1'b1, -32'sd1000, 32'd7, 1'b1, "");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      logic s;
      s = 1'($urandom);
      a = $urandom;
      b = $urandom;
      case ($urandom % 4)
        0: b = b >> ($urandom % 32);
        1: b = 32'($urandom % 16);
        default: ;
      endcase
      run_div(s, a, b, 1'b0, "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule